// File: doc/BRIEF.md
# Two-Source Leveled Interrupt Arbiter

This block is the interrupt slice for an audio serial port that emits two one-cycle event pulses: one when the transmit FIFO runs empty and one when the receive FIFO fills. Each source owns a sticky pending flag, an enable bit and a 3-bit level. Software reaches all of these through a small register port: a write strobe, a 2-bit address, 8-bit write data and a combinational read data bus.

Every cycle the block selects one winner from the sources that are both pending and enabled. The higher level wins. On equal levels the transmit-empty source wins. The winner's level is then compared with the processor's mask level. A request is raised only when the processor's global enable is set, the winning level is strictly above the mask, and no higher-priority cause is signalled. Together with the request, the block drives the winner's vector number and its vector address, which is a table base plus four times the vector number.

Top module: `irq_pair_arbiter`

## Requirements
- R1: A pulse on `tx_empty_evt_i` or `rx_full_evt_i` sets that source's flag to 1 at the next clock edge, whatever its enable bit holds.
- R2: Writing address 0 with a 1 in bit 0 clears the transmit flag, and a 1 in bit 1 clears the receive flag (write-one-to-clear). Reading address 0 returns the receive flag in bit 1 and the transmit flag in bit 0. An event in the same cycle as the clear leaves the flag set.
- R3: Address 1 holds the transmit enable in bit 0 and the receive enable in bit 1. A source with enable 0 never requests, and clearing its enable leaves its flag unchanged.
- R4: Address 2 holds the transmit level in bits 2:0 and the receive level in bits 6:4. Among the enabled pending sources, the one with the numerically higher level wins.
- R5: When both sources are enabled and pending with equal levels, the transmit-empty source wins.
- R6: A request is raised only when `cpu_ie_i` is 1 and the winning level is strictly greater than `cpu_mask_i`. A level equal to the mask, or level 0, gives no request.
- R7: While `urgent_i` is 1, no request is raised.
- R8: The transmit source presents vector 94 (0x5E) at `vec_base_i + 0x178`. The receive source presents vector 98 (0x62) at `vec_base_i + 0x188`. Without a request, vector and address are both 0.
- R9: After reset, flags, enables and levels all read 0 and all outputs are 0.
- R10: The request, vector and address outputs are registered. They change one clock edge after the state or input they depend on changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_empty_evt_i | input | 1 | Transmit FIFO empty event pulse |
| rx_full_evt_i | input | 1 | Receive FIFO full event pulse |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data (combinational) |
| cpu_ie_i | input | 1 | Processor global interrupt enable |
| cpu_mask_i | input | 3 | Processor current mask level |
| urgent_i | input | 1 | A higher-priority cause is present |
| vec_base_i | input | 32 | Vector table base address |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 8 | Vector number of the winner |
| irq_addr_o | output | 32 | Vector address of the winner |

## Verification
The hardest case to reach from the ports is a receive event landing in the very same cycle as a software clear of that flag. If the event lost, the flag would silently drop. The bench drives the write strobe and the event pulse together in one low clock phase, then reads the flag back and checks that the request persists. It also makes the enable, level and mask comparisons cross at exact equality, and samples the outputs both before and after the single register stage to confirm the one-edge latency.

// File: rtl/irq_pair_arbiter.sv
module irq_pair_arbiter #(
  parameter int          AW     = 32,
  parameter logic [7:0]  VEC_TX = 8'd94,
  parameter logic [7:0]  VEC_RX = 8'd98
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_empty_evt_i,
  input  logic          rx_full_evt_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [7:0]    cfg_wdata_i,
  output logic [7:0]    cfg_rdata_o,
  input  logic          cpu_ie_i,
  input  logic [2:0]    cpu_mask_i,
  input  logic          urgent_i,
  input  logic [AW-1:0] vec_base_i,
  output logic          irq_req_o,
  output logic [7:0]    irq_vec_o,
  output logic [AW-1:0] irq_addr_o
);
  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_LVL  = 2'd2;

  logic       flag_tx, flag_rx, en_tx, en_rx;
  logic [2:0] lvl_tx, lvl_rx;

  logic clr_tx, clr_rx;
  assign clr_tx = cfg_we_i && cfg_addr_i == A_FLAG && cfg_wdata_i[0];
  assign clr_rx = cfg_we_i && cfg_addr_i == A_FLAG && cfg_wdata_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_tx <= 1'b0;
      flag_rx <= 1'b0;
    end else begin
      flag_tx <= tx_empty_evt_i | (flag_tx & ~clr_tx);
      flag_rx <= rx_full_evt_i  | (flag_rx & ~clr_rx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_tx  <= 1'b0;
      en_rx  <= 1'b0;
      lvl_tx <= 3'd0;
      lvl_rx <= 3'd0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == A_EN) begin
        en_tx <= cfg_wdata_i[0];
        en_rx <= cfg_wdata_i[1];
      end
      if (cfg_addr_i == A_LVL) begin
        lvl_tx <= cfg_wdata_i[2:0];
        lvl_rx <= cfg_wdata_i[6:4];
      end
    end
  end

  logic unused_wbits;
  assign unused_wbits = cfg_wdata_i[7] ^ cfg_wdata_i[3];

  always_comb begin
    case (cfg_addr_i)
      A_FLAG:  cfg_rdata_o = {6'd0, flag_rx, flag_tx};
      A_EN:    cfg_rdata_o = {6'd0, en_rx, en_tx};
      A_LVL:   cfg_rdata_o = {1'b0, lvl_rx, 1'b0, lvl_tx};
      default: cfg_rdata_o = 8'd0;
    endcase
  end

  logic          cand_tx, cand_rx, rx_wins, take;
  logic [2:0]    win_lvl;
  logic [7:0]    nxt_vec;
  logic [AW-1:0] nxt_addr;

  assign cand_tx  = flag_tx & en_tx;
  assign cand_rx  = flag_rx & en_rx;
  assign rx_wins  = cand_rx & (~cand_tx | (lvl_rx > lvl_tx));
  assign win_lvl  = rx_wins ? lvl_rx : lvl_tx;
  assign take     = (cand_tx | cand_rx) & cpu_ie_i & ~urgent_i & (win_lvl > cpu_mask_i);
  assign nxt_vec  = take ? (rx_wins ? VEC_RX : VEC_TX) : 8'd0;
  assign nxt_addr = take ? vec_base_i + AW'({nxt_vec, 2'b00}) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req_o  <= 1'b0;
      irq_vec_o  <= 8'd0;
      irq_addr_o <= '0;
    end else begin
      irq_req_o  <= take;
      irq_vec_o  <= nxt_vec;
      irq_addr_o <= nxt_addr;
    end
  end

  assert_evt_sets_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt_i |=> flag_tx);
  assert_evt_sets_rx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_evt_i |=> flag_rx);
  assert_set_beats_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_evt_i && clr_rx) |=> flag_rx);
  assert_enable_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_vec_o == VEC_TX) |-> $past(en_tx && flag_tx));
  assert_tie_to_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_tx && cand_rx && lvl_tx == lvl_rx) |=> (!irq_req_o || irq_vec_o == VEC_TX));
  assert_needs_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> $past(cpu_ie_i));
  assert_urgent_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_i |=> !irq_req_o);
  assert_vec_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o == VEC_TX || irq_vec_o == VEC_RX));
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_o |-> (irq_vec_o == 8'd0 && irq_addr_o == '0));
endmodule

// File: tb/irq_pair_arbiter_tb.sv
module irq_pair_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_evt = 1'b0, rx_evt = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic        ie = 1'b0;
  logic [2:0]  mask = 3'd0;
  logic        urgent = 1'b0;
  logic [31:0] base = 32'd0;
  logic        req;
  logic [7:0]  vec;
  logic [31:0] vaddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pair_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .tx_empty_evt_i(tx_evt), .rx_full_evt_i(rx_evt),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .cpu_ie_i(ie), .cpu_mask_i(mask), .urgent_i(urgent), .vec_base_i(base),
    .irq_req_o(req), .irq_vec_o(vec), .irq_addr_o(vaddr)
  );

  typedef struct {
    bit        req;
    bit [7:0]  vec;
    bit [31:0] addr;
    string     tag;
  } exp_t;
  exp_t sb[$];

  initial begin
    forever begin
      wait (sb.size() > 0);
      begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (req !== e.req || vec !== e.vec || vaddr !== e.addr) begin
          errors++;
          $display("FAIL %s: got req=%0b vec=%0d addr=%h, expected req=%0b vec=%0d addr=%h",
                   e.tag, req, vec, vaddr, e.req, e.vec, e.addr);
        end
      end
    end
  end

  task automatic expect_out(input int edges, input bit r, input bit [7:0] v,
                            input bit [31:0] a, input string tag);
    exp_t e;
    repeat (edges) @(posedge clk);
    #2;
    e.req = r; e.vec = v; e.addr = a; e.tag = tag;
    sb.push_back(e);
    #1;
    if (edges > 0) @(negedge clk);
  endtask

  task automatic rd_check(input bit [1:0] a, input bit [7:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_tx();
    tx_evt = 1'b1;
    @(negedge clk);
    tx_evt = 1'b0;
  endtask

  task automatic pulse_rx();
    rx_evt = 1'b1;
    @(negedge clk);
    rx_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out(1, 0, 0, 0, "R9 outputs after reset");
    rd_check(2'd0, 8'h00, "R9 flags reset");
    rd_check(2'd1, 8'h00, "R9 enables reset");
    rd_check(2'd2, 8'h00, "R9 levels reset");

    ie = 1'b1; mask = 3'd0; base = 32'h0000_1000;
    pulse_tx();
    rd_check(2'd0, 8'h01, "R1 flag set while disabled");
    expect_out(2, 0, 0, 0, "R3 disabled source quiet");

    wr(2'd1, 8'h01);
    expect_out(2, 0, 0, 0, "R6 level 0 never above mask");
    wr(2'd2, 8'h03);
    expect_out(2, 1, 94, 32'h0000_1178, "R8 tx vector");

    wr(2'd1, 8'h00);
    expect_out(2, 0, 0, 0, "R3 enable cleared");
    rd_check(2'd0, 8'h01, "R3 flag kept");

    wr(2'd1, 8'h01);
    pulse_rx();
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h53);
    expect_out(2, 1, 98, 32'h0000_1188, "R4 rx higher");
    wr(2'd2, 8'h33);
    expect_out(2, 1, 94, 32'h0000_1178, "R5 tie favours tx");
    wr(2'd2, 8'h73);
    expect_out(2, 1, 98, 32'h0000_1188, "R4 rx 7 over tx 3");
    wr(2'd2, 8'h23);
    expect_out(2, 1, 94, 32'h0000_1178, "R4 tx 3 over rx 2");

    mask = 3'd3;
    expect_out(1, 0, 0, 0, "R6 R10 level equal to mask");
    mask = 3'd2;
    expect_out(1, 1, 94, 32'h0000_1178, "R6 R10 level above mask");
    ie = 1'b0;
    expect_out(1, 0, 0, 0, "R6 global enable off");
    ie = 1'b1;
    expect_out(1, 1, 94, 32'h0000_1178, "R6 global enable on");
    urgent = 1'b1;
    expect_out(1, 0, 0, 0, "R7 urgent cause");
    urgent = 1'b0;
    expect_out(1, 1, 94, 32'h0000_1178, "R7 urgent released");
    base = 32'h0000_2000;
    expect_out(1, 1, 94, 32'h0000_2178, "R8 new base");

    wr(2'd2, 8'h53);
    expect_out(2, 1, 98, 32'h0000_2188, "R8 rx vector new base");
    wr(2'd0, 8'h02);
    expect_out(0, 1, 98, 32'h0000_2188, "R10 output held one edge");
    rd_check(2'd0, 8'h01, "R2 rx flag cleared");
    expect_out(1, 1, 94, 32'h0000_2178, "R2 tx takes over after clear");

    we = 1'b1; addr = 2'd0; wdata = 8'h02; rx_evt = 1'b1;
    @(negedge clk);
    we = 1'b0; rx_evt = 1'b0;
    rd_check(2'd0, 8'h03, "R2 set wins over clear");
    expect_out(1, 1, 98, 32'h0000_2188, "R2 request after collision");

    wr(2'd0, 8'h03);
    rd_check(2'd0, 8'h00, "R2 both flags cleared");
    expect_out(1, 0, 0, 0, "R2 no request after clear");

    wait (sb.size() == 0);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule